// File: doc/BRIEF.md
# Reset Source Aggregation Controller

This block merges every reset request of a chip into one synchronous system reset. It also drives the shared open-drain reset pad low for a minimum stretch. The pad is modelled as a sensed level `pin_in` and a drive-low enable `pin_oe`; the pad cell itself sits outside the block. The causes are:

- a cold power-on reset, or a voltage-monitor fault;
- an external device pulling the reset pad low;
- an oscillator failure, which resets the chip only when a configuration enable allows it;
- a software command written to a control register;
- a CPU reset request;
- debug and watchdog requests.

A power-on cause keeps the pad low for a long stretch. Every other cause uses a short warm stretch. Each cause leaves a sticky flag in a 16-bit status register. Software clears a flag by writing a one to it. The pad is driven by the block and then read back, so the external-reset flag (bit 3) is set for every reset cause. After the stretch the block waits until it senses the pad high again, and then releases the system reset.

The sequencer is a four-state machine:

- `ST_POR_HOLD` is the long power-on stretch.
- `ST_WARM_HOLD` is the short warm stretch.
- `ST_RELEASE` waits for the pad to read high.
- `ST_RUN` is normal operation.

Its transitions are:

- `por_enter`: from any state, on `por_n` low or on `vmon_fault`. The counter restarts.
- `warm_enter`: `ST_RUN` to `ST_WARM_HOLD`, on any warm cause.
- `stretch_done`: a hold state to `ST_RELEASE`, when the counter reaches its last value.
- `pin_free`: `ST_RELEASE` to `ST_RUN`, when the synchronized pad reads high.

Top module: `sysrst_ctrl`

## Requirements
- R1: While `por_n` is low, and in the cycle after any cycle with `vmon_fault` high, the status register equals 16'h8008 (bit 15 power-on, bit 3 pad) with all other bits cleared, and the control register equals 16'h4000.
- R2: After `por_n` rises, or after a `vmon_fault` cycle (even during a stretch already under way), `pin_oe` stays high for exactly POR_CYCLES clock edges.
- R3: A warm cause seen in `ST_RUN` raises `pin_oe` at the next edge and holds it for exactly WARM_CYCLES edges. `pin_oe` is never high while `sys_rst_n` is high.
- R4: `pin_in` passes through a two-flop synchronizer. If `pin_oe` falls at edge E and the pad is free, `sys_rst_n` rises at edge E+3. While the pad is held low from outside, `sys_rst_n` stays low.
- R5: The start of every reset sets status bit 3. A low synchronized pad in `ST_RUN` starts a warm reset. The block's own drive of the pad never starts another reset.
- R6: `osc_fail` sets status bit 14 in any state. It starts a reset only when `osc_rst_en` is high.
- R7: A write to the control register (`reg_sel`=0) with data bit 15 = 1, or with data bit 14 = 0, starts a warm reset and sets status bit 4; the control register then returns to 16'h4000. Any other write is stored and read back, with no reset.
- R8: `cpu_rst_req` sets status bit 5. `dbg_rst_req` and `wdog_rst_req` both set status bit 13. Each of them starts a warm reset.
- R9: A write to the status register (`reg_sel`=1) clears each flag whose data bit is 1. A flag that is being set in the same cycle stays set.
- R10: Status flags survive warm resets. A request that arrives during a stretch only sets its flag and does not restart the stretch.
- R11: Bus writes to either register are ignored while `sys_rst_n` is low.
- R12: `reg_rdata` shows the control register when `reg_sel`=0 and the status register when `reg_sel`=1. Status bits other than 15, 14, 13, 5, 4 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| vmon_fault | input | 1 | Voltage-monitor fault, treated as power-on |
| pin_in | input | 1 | Sensed level of the reset pad |
| pin_oe | output | 1 | Drive the reset pad low |
| osc_fail | input | 1 | Oscillator failure event |
| osc_rst_en | input | 1 | Allows an oscillator failure to reset the chip |
| cpu_rst_req | input | 1 | CPU reset request |
| dbg_rst_req | input | 1 | Debug reset request |
| wdog_rst_req | input | 1 | Watchdog reset request |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the status register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| sys_rst_n | output | 1 | System reset, active low, released synchronously |

## Verification
The bench builds the block with POR_CYCLES = 100 and keeps WARM_CYCLES at its default of 32. This makes the exact length of the power-on stretch countable, including a restart from a voltage fault that arrives in the middle of a warm stretch. The bench models the pad as a wired-AND of the block's drive and an external driver. With that model it can hold the pad low beyond the stretch, pulse it for a single cycle, and confirm that the block's own drive never starts a second reset.

// File: rtl/rsa_pkg.sv
package rsa_pkg;

    localparam int REG_W = 16;

    // Status flag positions; software decodes these.
    localparam int FLG_POR  = 15;
    localparam int FLG_OSC  = 14;
    localparam int FLG_WDG  = 13;
    localparam int FLG_CPU  = 5;
    localparam int FLG_SW   = 4;
    localparam int FLG_PIN  = 3;

    // Control bits that trigger a software reset.
    localparam int CTL_FIRE = 15;
    localparam int CTL_HOLD = 14;

    localparam logic [REG_W-1:0] CTRL_INIT = 16'h4000;
    localparam logic [REG_W-1:0] STAT_POR  = 16'h8008;
    localparam logic [REG_W-1:0] STAT_IMPL = 16'hE038;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_POR_HOLD  = 2'd1,
        ST_WARM_HOLD = 2'd2,
        ST_RELEASE   = 2'd3
    } rst_state_e;

endpackage

// File: rtl/rsa_pin_sync.sv
module rsa_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        genvar g;
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rsa_cause_decode.sv
module rsa_cause_decode
    import rsa_pkg::*;
(
    input  logic             in_run,
    input  logic             pin_hi,
    input  logic             vmon_fault,
    input  logic             osc_fail,
    input  logic             osc_rst_en,
    input  logic             cpu_rst_req,
    input  logic             dbg_rst_req,
    input  logic             wdog_rst_req,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic             por_evt,
    output logic             warm_evt,
    output logic             ctrl_wr,
    output logic [REG_W-1:0] set_mask,
    output logic [REG_W-1:0] clr_mask
);
    logic sw_evt;
    logic ext_evt;

    always_comb begin
        por_evt  = vmon_fault;
        ext_evt  = in_run && !pin_hi;
        sw_evt   = in_run && reg_wr && !reg_sel &&
                   (reg_wdata[CTL_FIRE] || !reg_wdata[CTL_HOLD]);
        warm_evt = in_run && (ext_evt || cpu_rst_req || dbg_rst_req ||
                   wdog_rst_req || (osc_fail && osc_rst_en) || sw_evt);
        ctrl_wr  = in_run && reg_wr && !reg_sel;
        clr_mask = (in_run && reg_wr && reg_sel) ? reg_wdata : '0;

        set_mask          = '0;
        set_mask[FLG_OSC] = osc_fail;
        set_mask[FLG_CPU] = cpu_rst_req;
        set_mask[FLG_WDG] = dbg_rst_req || wdog_rst_req;
        set_mask[FLG_SW]  = sw_evt;
        set_mask[FLG_PIN] = warm_evt;
    end
endmodule

// File: rtl/rsa_regs.sv
module rsa_regs
    import rsa_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             por_evt,
    input  logic             warm_evt,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] set_mask,
    input  logic [REG_W-1:0] clr_mask,
    output logic [REG_W-1:0] status_q,
    output logic [REG_W-1:0] ctrl_q
);
    logic [REG_W-1:0] status_n;
    logic [REG_W-1:0] ctrl_n;

    always_comb begin
        if (por_evt) begin
            status_n = STAT_POR;
            ctrl_n   = CTRL_INIT;
        end else begin
            status_n = ((status_q & ~clr_mask) | set_mask) & STAT_IMPL;
            if (warm_evt)     ctrl_n = CTRL_INIT;
            else if (ctrl_wr) ctrl_n = wdata;
            else              ctrl_n = ctrl_q;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            status_q <= STAT_POR;
            ctrl_q   <= CTRL_INIT;
        end else begin
            status_q <= status_n;
            ctrl_q   <= ctrl_n;
        end
    end

    // R1
    por_image_chk: assert property (@(posedge clk) disable iff (!por_n)
        por_evt |=> (status_q == STAT_POR) && (ctrl_q == CTRL_INIT));

    // R10
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!por_evt && clr_mask == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/rsa_seq_fsm.sv
module rsa_seq_fsm
    import rsa_pkg::*;
#(
    parameter int POR_CYCLES  = 2048,
    parameter int WARM_CYCLES = 32
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       por_evt,
    input  logic       warm_evt,
    input  logic       pin_hi,
    output rst_state_e state_q,
    output logic       pin_oe,
    output logic       sys_rst_n
);
    localparam int MAX_LEN = (POR_CYCLES > WARM_CYCLES) ? POR_CYCLES : WARM_CYCLES;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_CYCLES - 1);
    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARM_CYCLES - 1);

    rst_state_e       state_n;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;

    // next-state and counter
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (por_evt) begin
            state_n = ST_POR_HOLD;          // por_enter
            cnt_n   = '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (warm_evt) begin
                        state_n = ST_WARM_HOLD; // warm_enter
                        cnt_n   = '0;
                    end
                end
                ST_POR_HOLD: begin
                    if (cnt_q == POR_LAST) state_n = ST_RELEASE; // stretch_done
                    else                   cnt_n   = cnt_q + CNT_W'(1);
                end
                ST_WARM_HOLD: begin
                    if (cnt_q == WARM_LAST) state_n = ST_RELEASE; // stretch_done
                    else                    cnt_n   = cnt_q + CNT_W'(1);
                end
                ST_RELEASE: begin
                    if (pin_hi) state_n = ST_RUN;  // pin_free
                end
                default: state_n = ST_POR_HOLD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_POR_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pin_oe    <= 1'b1;
            sys_rst_n <= 1'b0;
        end else begin
            pin_oe    <= (state_n == ST_POR_HOLD) || (state_n == ST_WARM_HOLD);
            sys_rst_n <= (state_n == ST_RUN);
        end
    end

    // checker: length of the current drive-low run
    localparam int LEN_W = $clog2(WARM_CYCLES + 1);
    logic [LEN_W-1:0] oe_len;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                                   oe_len <= '0;
        else if (!pin_oe)                             oe_len <= '0;
        else if (oe_len < LEN_W'(WARM_CYCLES))        oe_len <= oe_len + LEN_W'(1);
    end

    // R3
    min_stretch_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(pin_oe) |-> (oe_len == LEN_W'(WARM_CYCLES)));

    // R3
    oe_in_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
        pin_oe |-> !sys_rst_n);

    // R4
    release_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_n) |-> ($past(pin_hi) && !$past(pin_oe)));
endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
    import rsa_pkg::*;
#(
    parameter int POR_CYCLES  = 2048,
    parameter int WARM_CYCLES = 32
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             vmon_fault,
    input  logic             pin_in,
    output logic             pin_oe,
    input  logic             osc_fail,
    input  logic             osc_rst_en,
    input  logic             cpu_rst_req,
    input  logic             dbg_rst_req,
    input  logic             wdog_rst_req,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             sys_rst_n
);
    rst_state_e       state_q;
    logic             pin_hi;
    logic             por_evt;
    logic             warm_evt;
    logic             ctrl_wr;
    logic [REG_W-1:0] set_mask;
    logic [REG_W-1:0] clr_mask;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] ctrl_q;
    logic             in_run;

    assign in_run = (state_q == ST_RUN);

    rsa_pin_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .din   (pin_in),
        .dout  (pin_hi)
    );

    rsa_cause_decode u_cause (
        .in_run       (in_run),
        .pin_hi       (pin_hi),
        .vmon_fault   (vmon_fault),
        .osc_fail     (osc_fail),
        .osc_rst_en   (osc_rst_en),
        .cpu_rst_req  (cpu_rst_req),
        .dbg_rst_req  (dbg_rst_req),
        .wdog_rst_req (wdog_rst_req),
        .reg_wr       (reg_wr),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .por_evt      (por_evt),
        .warm_evt     (warm_evt),
        .ctrl_wr      (ctrl_wr),
        .set_mask     (set_mask),
        .clr_mask     (clr_mask)
    );

    rsa_regs u_regs (
        .clk      (clk),
        .por_n    (por_n),
        .por_evt  (por_evt),
        .warm_evt (warm_evt),
        .ctrl_wr  (ctrl_wr),
        .wdata    (reg_wdata),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .status_q (status_q),
        .ctrl_q   (ctrl_q)
    );

    rsa_seq_fsm #(
        .POR_CYCLES  (POR_CYCLES),
        .WARM_CYCLES (WARM_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .por_evt   (por_evt),
        .warm_evt  (warm_evt),
        .pin_hi    (pin_hi),
        .state_q   (state_q),
        .pin_oe    (pin_oe),
        .sys_rst_n (sys_rst_n)
    );

    assign reg_rdata = reg_sel ? status_q : ctrl_q;

    // R5
    pin_flag_on_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst_n) |-> status_q[FLG_PIN]);

    // R6
    osc_gated_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && osc_fail && !osc_rst_en && pin_hi && !vmon_fault &&
         !cpu_rst_req && !dbg_rst_req && !wdog_rst_req && !reg_wr) |=> sys_rst_n);

    // R7
    sw_fire_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && reg_wr && !reg_sel && !vmon_fault &&
         (reg_wdata[CTL_FIRE] || !reg_wdata[CTL_HOLD]))
        |=> (!sys_rst_n && status_q[FLG_SW] && ctrl_q == CTRL_INIT));

    // R11
    bus_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && !vmon_fault) |=> (ctrl_q == CTRL_INIT));
endmodule

// File: tb/tb_sysrst_ctrl.sv
module tb_sysrst_ctrl;
    localparam int POR_C  = 100;
    localparam int WARM_C = 32;

    logic        clk = 1'b0;
    logic        por_n, vmon_fault, osc_fail, osc_rst_en;
    logic        cpu_rst_req, dbg_rst_req, wdog_rst_req;
    logic        reg_wr, reg_sel, ext_low;
    logic [15:0] reg_wdata, reg_rdata;
    logic        pin_oe, sys_rst_n, pin_in;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    assign pin_in = !(pin_oe || ext_low);

    sysrst_ctrl #(.POR_CYCLES(POR_C), .WARM_CYCLES(WARM_C)) dut (
        .clk(clk), .por_n(por_n), .vmon_fault(vmon_fault), .pin_in(pin_in),
        .pin_oe(pin_oe), .osc_fail(osc_fail), .osc_rst_en(osc_rst_en),
        .cpu_rst_req(cpu_rst_req), .dbg_rst_req(dbg_rst_req),
        .wdog_rst_req(wdog_rst_req), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst_n(sys_rst_n)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // behavioural reference: 0 run, 1 power-on hold, 2 warm hold, 3 release
    int          m_state, m_cnt;
    bit          m_s1, m_s2, m_oe, m_rst, m_pin, m_run, m_sw, m_warm;
    logic [15:0] m_stat, m_ctrl;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_state = 1; m_cnt = 0; m_s1 = 0; m_s2 = 0;
            m_stat = 16'h8008; m_ctrl = 16'h4000; m_oe = 1; m_rst = 0;
        end else begin
            m_pin  = !(m_oe || ext_low);
            m_run  = (m_state == 0);
            m_sw   = m_run && reg_wr && !reg_sel && (reg_wdata[15] || !reg_wdata[14]);
            m_warm = m_run && (!m_s2 || cpu_rst_req || dbg_rst_req || wdog_rst_req ||
                     (osc_fail && osc_rst_en) || m_sw);
            if (vmon_fault) begin
                m_stat = 16'h8008; m_ctrl = 16'h4000;
                m_state = 1; m_cnt = 0;
            end else begin
                if (m_run && reg_wr && reg_sel) m_stat = m_stat & ~reg_wdata;
                if (osc_fail) m_stat[14] = 1'b1;
                if (cpu_rst_req) m_stat[5] = 1'b1;
                if (dbg_rst_req || wdog_rst_req) m_stat[13] = 1'b1;
                if (m_sw) m_stat[4] = 1'b1;
                if (m_warm) m_stat[3] = 1'b1;
                if (m_warm) m_ctrl = 16'h4000;
                else if (m_run && reg_wr && !reg_sel) m_ctrl = reg_wdata;
                case (m_state)
                    0: if (m_warm) begin m_state = 2; m_cnt = 0; end
                    1: if (m_cnt == POR_C - 1) m_state = 3; else m_cnt++;
                    2: if (m_cnt == WARM_C - 1) m_state = 3; else m_cnt++;
                    default: if (m_s2) m_state = 0;
                endcase
            end
            m_s2 = m_s1; m_s1 = m_pin;
            m_oe  = (m_state == 1) || (m_state == 2);
            m_rst = (m_state == 0);
        end
    end

    // compare every clock, half way between edges
    always @(posedge clk) begin
        #5;
        chk("R4 model sys_rst_n", sys_rst_n, m_rst);
        chk("R3 model pin_oe", pin_oe, m_oe);
        chk("R12 model reg_rdata", reg_rdata, reg_sel ? m_stat : m_ctrl);
    end

    task automatic rd(input logic sel, output logic [15:0] v);
        @(negedge clk); reg_sel = sel; #1 v = reg_rdata;
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic oe_count(output int n);
        n = 0;
        for (int i = 0; i < 6 && !pin_oe; i++) @(negedge clk);
        while (pin_oe && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_run();
        for (int i = 0; i < 1000 && !sys_rst_n; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        wr(1'b1, 16'hFFFF);
    endtask

    logic [15:0] v;
    int          n;

    initial begin
        por_n = 0; vmon_fault = 0; osc_fail = 0; osc_rst_en = 0;
        cpu_rst_req = 0; dbg_rst_req = 0; wdog_rst_req = 0;
        reg_wr = 0; reg_sel = 0; reg_wdata = 0; ext_low = 0;
        repeat (3) @(negedge clk);
        rd(1'b1, v); chk("R1 status in power-on", v, 16'h8008);
        rd(1'b0, v); chk("R1 control in power-on", v, 16'h4000);
        chk("R3 pad driven in power-on", pin_oe, 1);
        chk("R4 reset held in power-on", sys_rst_n, 0);

        @(negedge clk); por_n = 1;
        oe_count(n); chk("R2 power-on stretch", n, POR_C);
        @(negedge clk); @(negedge clk);
        chk("R4 still in reset at E+2", sys_rst_n, 0);
        @(negedge clk);
        chk("R4 released at E+3", sys_rst_n, 1);

        clear_all();
        rd(1'b1, v); chk("R9 write-one clear", v, 16'h0000);

        @(negedge clk); cpu_rst_req = 1; @(negedge clk); cpu_rst_req = 0;
        oe_count(n); chk("R3 warm stretch", n, WARM_C);
        wait_run();
        rd(1'b1, v); chk("R8 cpu flag", v, 16'h0028);
        repeat (40) @(negedge clk);
        chk("R5 own drive ignored", sys_rst_n, 1);

        @(negedge clk); dbg_rst_req = 1; @(negedge clk); dbg_rst_req = 0;
        wait_run();
        rd(1'b1, v); chk("R10 flags sticky", v, 16'h2028);
        wr(1'b1, 16'h0020);
        rd(1'b1, v); chk("R9 partial clear", v, 16'h2008);
        clear_all();

        @(negedge clk); wdog_rst_req = 1; @(negedge clk); wdog_rst_req = 0;
        wait_run();
        rd(1'b1, v); chk("R8 watchdog flag", v, 16'h2008);
        clear_all();

        wr(1'b0, 16'h4001);
        chk("R7 plain write no reset", sys_rst_n, 1);
        rd(1'b0, v); chk("R7 control readback", v, 16'h4001);
        wr(1'b0, 16'hC001);
        chk("R7 fire bit resets", sys_rst_n, 0);
        wait_run();
        rd(1'b1, v); chk("R7 software flag", v, 16'h0018);
        rd(1'b0, v); chk("R7 control restored", v, 16'h4000);
        clear_all();
        wr(1'b0, 16'h0000);
        chk("R7 hold bit zero resets", sys_rst_n, 0);
        wait_run();
        rd(1'b1, v); chk("R7 software flag again", v, 16'h0018);
        clear_all();

        osc_rst_en = 0;
        @(negedge clk); osc_fail = 1; @(negedge clk); osc_fail = 0;
        repeat (5) @(negedge clk);
        chk("R6 oscillator gated off", sys_rst_n, 1);
        rd(1'b1, v); chk("R6 oscillator flag only", v, 16'h4000);
        clear_all();
        osc_rst_en = 1;
        @(negedge clk); osc_fail = 1; @(negedge clk); osc_fail = 0;
        oe_count(n); chk("R6 oscillator reset stretch", n, WARM_C);
        wait_run();
        rd(1'b1, v); chk("R6 oscillator reset flags", v, 16'h4008);
        clear_all();
        osc_rst_en = 0;

        @(negedge clk); ext_low = 1;
        repeat (60) @(negedge clk);
        chk("R4 held while pad low", sys_rst_n, 0);
        ext_low = 0;
        wait_run();
        rd(1'b1, v); chk("R5 external hold flag", v, 16'h0008);
        clear_all();
        @(negedge clk); ext_low = 1; @(negedge clk); ext_low = 0;
        wait_run();
        rd(1'b1, v); chk("R5 one-cycle pad pulse", v, 16'h0008);
        clear_all();

        @(negedge clk); cpu_rst_req = 1; @(negedge clk); cpu_rst_req = 0;
        wr(1'b1, 16'hFFFF);
        wr(1'b0, 16'h8000);
        wait_run();
        rd(1'b1, v); chk("R11 status write ignored", v, 16'h0028);
        rd(1'b0, v); chk("R11 control write ignored", v, 16'h4000);
        repeat (5) @(negedge clk);
        chk("R11 no software reset", sys_rst_n, 1);
        clear_all();

        @(negedge clk);
        cpu_rst_req = 1; reg_wr = 1; reg_sel = 1; reg_wdata = 16'h0020;
        @(negedge clk); cpu_rst_req = 0; reg_wr = 0;
        wait_run();
        rd(1'b1, v); chk("R9 set beats clear", v, 16'h0028);
        clear_all();

        @(negedge clk); cpu_rst_req = 1; @(negedge clk); cpu_rst_req = 0;
        repeat (5) @(negedge clk);
        wdog_rst_req = 1; @(negedge clk); wdog_rst_req = 0;
        wait_run();
        rd(1'b1, v); chk("R10 request during stretch", v, 16'h2028);

        @(negedge clk); vmon_fault = 1; @(negedge clk); vmon_fault = 0;
        oe_count(n); chk("R2 voltage fault stretch", n, POR_C);
        rd(1'b1, v); chk("R1 voltage fault image", v, 16'h8008);
        rd(1'b0, v); chk("R1 voltage fault control", v, 16'h4000);
        wait_run();

        @(negedge clk); cpu_rst_req = 1; @(negedge clk); cpu_rst_req = 0;
        repeat (3) @(negedge clk);
        vmon_fault = 1; @(negedge clk); vmon_fault = 0;
        oe_count(n); chk("R2 restart from warm stretch", n, POR_C);
        wait_run();
        rd(1'b1, v); chk("R1 image after restart", v, 16'h8008);
        rd(1'b0, v); chk("R12 control select", v, 16'h4000);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule